// File: doc/BRIEF.md
# Serial Word Transmitter with Holding Buffer

This block is the sending side of a synchronous serial port. The host places a word into a one-entry holding buffer. As soon as the shifter is idle, the word moves into the shifter. It then leaves on a single data line, most significant bit first, with one bit per period of the transmit bit clock. The bit clock reaches the block as a one-cycle enable, `bit_tick_i`, sampled on the internal clock. Every word is preceded by a one-period frame sync. The block drives that sync itself when `fs_dir_i` is 1. When `fs_dir_i` is 0, the block waits for the sync on `fs_i`.

Because the buffer and the shifter are separate, the host can write the next word while the current one is still being sent. A ready flag tells the host when the buffer is free again. It reads 1 out of reset and is set a fixed number of internal cycles after each transfer into the shifter. A one-cycle interrupt pulse marks each rise of the ready flag. A busy flag reads 1 while the shifter holds a word. A synchronous transmit reset, `xmt_rst_i`, clears the shifter and the buffer without involving the system reset.

Top module: `sertx_xmit`

## Requirements
- R1: While reset is active and on the first cycle after it, `tx_ready_o`=1, `tx_int_o`=0, `sr_busy_o`=0, `dx_o`=0 and `fs_o`=0.
- R2: A host write with `xmt_rst_i`=0 makes `tx_ready_o` read 0 after the next rising clock edge. It stays 0 until that word has moved into the shifter.
- R3: A buffered word moves into the shifter on the first edge at which the shifter is idle. `tx_ready_o` rises exactly READY_LAT (default 3) edges after that transfer edge. From an idle block this is READY_LAT+1 edges after the write edge.
- R4: `tx_int_o` is a single-cycle pulse in the first cycle that `tx_ready_o` reads 1 after reading 0. It does not pulse out of reset or out of a transmit reset.
- R5: `sr_busy_o` reads 1 from the transfer edge until the edge of the bit tick that ends the last bit. It then reads 0.
- R6: Bits leave MSB first. Each bit is held on `dx_o` for one bit period, from one tick edge to the next. `dx_o` reads 0 whenever the shifter is not sending a bit.
- R7: With `fs_dir_i`=1, `fs_oe_o`=1. After the word is loaded, the first tick starts a sync period in which `fs_o`=1. The next tick ends the sync and begins the MSB. `fs_o` is high for exactly that one period per word.
- R8: With `fs_dir_i`=0, `fs_oe_o`=0 and `fs_o`=0. A loaded word waits through ticks with `fs_i`=0. A tick with `fs_i`=1 ends the sync period, and the MSB follows in the next period.
- R9: One cycle of `xmt_rst_i` drops any word in the buffer or shifter. On the next edge it sets `sr_busy_o`=0, `dx_o`=0 and `tx_ready_o`=1, with no interrupt. A host write in that same cycle is ignored.
- R10: A word written while the shifter is busy waits in the buffer with `tx_ready_o`=0. It moves in on the edge after the current word's last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous system reset, active low |
| xmt_rst_i | input | 1 | Synchronous transmit reset |
| wr_en_i | input | 1 | Host write strobe for the holding buffer |
| wr_data_i | input | DATA_W | Word to send |
| bit_tick_i | input | 1 | One-cycle enable marking each transmit bit clock |
| fs_dir_i | input | 1 | Frame sync direction: 1 drive, 0 sample |
| fs_i | input | 1 | Frame sync from outside, used when fs_dir_i=0 |
| fs_o | output | 1 | Frame sync driven by the block |
| fs_oe_o | output | 1 | Output enable for the frame sync pad |
| dx_o | output | 1 | Serial data out |
| tx_ready_o | output | 1 | Holding buffer can take a new word |
| tx_int_o | output | 1 | One-cycle pulse on each rise of the ready flag |
| sr_busy_o | output | 1 | Shifter holds a word |

## Verification
Some properties are checked by assertions on every cycle. A write always pulls ready low. A load never happens while ready is high. The interrupt pulse fires only with ready high and accompanies every ordinary rise of ready. `dx_o` stays quiet while the shifter is empty, and an internally driven sync lasts one tick. Sampled-sync mode never drives `fs_o`, and a transmit reset always returns the idle flags. Other behaviour needs the bench's scenarios. These cover the exact ready latency and the bit order of every word in both sync modes. They also cover words waiting behind a busy shifter, and the dropping of buffered and in-flight words by the transmit reset.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_WAIT  = 2'd1,
    SH_SYNC  = 2'd2,
    SH_SHIFT = 2'd3
  } sh_state_e;
endpackage

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
  parameter int W         = 8,
  parameter int READY_LAT = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         xrst_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         take_i,
  output logic         full_o,
  output logic [W-1:0] data_o,
  output logic         ready_o,
  output logic         int_o
);
  logic                 full_q;
  logic [W-1:0]         data_q;
  logic [READY_LAT-1:0] dly_q;
  logic                 ready_q;
  logic                 ready_prev_q;
  logic                 wr_ok;

  assign wr_ok = wr_en_i & ~xrst_i;

  // delay line from shifter load to ready
  if (READY_LAT > 1) begin : g_dly_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dly_q <= '0;
      else if (xrst_i) dly_q <= '0;
      else             dly_q <= {dly_q[READY_LAT-2:0], take_i};
    end
  end else begin : g_dly_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dly_q <= '0;
      else if (xrst_i) dly_q <= '0;
      else             dly_q <= take_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q       <= 1'b0;
      data_q       <= '0;
      ready_q      <= 1'b1;
      ready_prev_q <= 1'b1;
    end else if (xrst_i) begin
      full_q       <= 1'b0;
      ready_q      <= 1'b1;
      ready_prev_q <= 1'b1;
    end else begin
      ready_prev_q <= ready_q;
      if (take_i) full_q <= 1'b0;
      if (wr_ok) begin
        full_q <= 1'b1;
        data_q <= wr_data_i;
      end
      if (wr_ok)                              ready_q <= 1'b0;
      else if (dly_q[READY_LAT-1] && !full_q) ready_q <= 1'b1;
    end
  end

  assign full_o  = full_q;
  assign data_o  = data_q;
  assign ready_o = ready_q;
  assign int_o   = ready_q & ~ready_prev_q;
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         xrst_i,
  input  logic         tick_i,
  input  logic         fs_dir_i,
  input  logic         fs_i,
  input  logic         buf_full_i,
  input  logic [W-1:0] buf_data_i,
  output logic         take_o,
  output logic         dx_o,
  output logic         fs_o,
  output logic         busy_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  sh_state_e      state_q;
  logic [W-1:0]   sh_q;
  logic [CW-1:0]  cnt_q;

  assign take_o = (state_q == SH_IDLE) & buf_full_i & ~xrst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SH_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else if (xrst_i) begin
      state_q <= SH_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SH_IDLE: if (take_o) begin
          sh_q    <= buf_data_i;
          state_q <= SH_WAIT;
        end
        SH_WAIT: if (tick_i) begin
          if (fs_dir_i) begin
            state_q <= SH_SYNC;
          end else if (fs_i) begin
            state_q <= SH_SHIFT;
            cnt_q   <= '0;
          end
        end
        SH_SYNC: if (tick_i) begin
          state_q <= SH_SHIFT;
          cnt_q   <= '0;
        end
        SH_SHIFT: if (tick_i) begin
          if (cnt_q == CW'(W - 1)) begin
            state_q <= SH_IDLE;
            sh_q    <= '0;
          end else begin
            sh_q  <= sh_q << 1;
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != SH_IDLE);
  assign dx_o   = (state_q == SH_SHIFT) & sh_q[W-1];
  assign fs_o   = (state_q == SH_SYNC) & fs_dir_i;
endmodule

// File: rtl/sertx_xmit.sv
module sertx_xmit #(
  parameter int DATA_W    = 8,
  parameter int READY_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xmt_rst_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              bit_tick_i,
  input  logic              fs_dir_i,
  input  logic              fs_i,
  output logic              fs_o,
  output logic              fs_oe_o,
  output logic              dx_o,
  output logic              tx_ready_o,
  output logic              tx_int_o,
  output logic              sr_busy_o
);
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              take;

  sertx_holdbuf #(
    .W         (DATA_W),
    .READY_LAT (READY_LAT)
  ) u_holdbuf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .xrst_i    (xmt_rst_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .full_o    (buf_full),
    .data_o    (buf_data),
    .ready_o   (tx_ready_o),
    .int_o     (tx_int_o)
  );

  sertx_shifter #(
    .W (DATA_W)
  ) u_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .xrst_i     (xmt_rst_i),
    .tick_i     (bit_tick_i),
    .fs_dir_i   (fs_dir_i),
    .fs_i       (fs_i),
    .buf_full_i (buf_full),
    .buf_data_i (buf_data),
    .take_o     (take),
    .dx_o       (dx_o),
    .fs_o       (fs_o),
    .busy_o     (sr_busy_o)
  );

  assign fs_oe_o = fs_dir_i;
endmodule

// File: rtl/sertx_xmit_chk.sv
module sertx_xmit_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic xmt_rst_i,
  input logic wr_en_i,
  input logic bit_tick_i,
  input logic fs_dir_i,
  input logic fs_o,
  input logic dx_o,
  input logic tx_ready_o,
  input logic tx_int_o,
  input logic sr_busy_o
);
  p_rdy_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !xmt_rst_i |=> !tx_ready_o);

  p_load_rdy_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sr_busy_o) |-> !tx_ready_o);

  p_int_on_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ready_o) && !$past(xmt_rst_i) |-> tx_int_o);

  p_int_needs_rdy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_int_o |-> tx_ready_o);

  p_dx_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_busy_o |-> !dx_o);

  p_fs_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_o && bit_tick_i |=> !fs_o);

  p_fs_in_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_dir_i |-> !fs_o);

  p_xrst_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xmt_rst_i |=> !sr_busy_o && tx_ready_o && !tx_int_o);
endmodule

bind sertx_xmit sertx_xmit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .xmt_rst_i  (xmt_rst_i),
  .wr_en_i    (wr_en_i),
  .bit_tick_i (bit_tick_i),
  .fs_dir_i   (fs_dir_i),
  .fs_o       (fs_o),
  .dx_o       (dx_o),
  .tx_ready_o (tx_ready_o),
  .tx_int_o   (tx_int_o),
  .sr_busy_o  (sr_busy_o)
);

// File: tb/sertx_xmit_tb.sv
module sertx_xmit_tb_top;
  localparam int W   = 4;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         xmt_rst = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         bit_tick = 1'b0;
  logic         fs_dir = 1'b0;
  logic         fs_in = 1'b0;
  logic         fs_o, fs_oe, dx, tx_ready, tx_int, sr_busy;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  sertx_xmit #(.DATA_W(W), .READY_LAT(LAT)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .xmt_rst_i  (xmt_rst),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .bit_tick_i (bit_tick),
    .fs_dir_i   (fs_dir),
    .fs_i       (fs_in),
    .fs_o       (fs_o),
    .fs_oe_o    (fs_oe),
    .dx_o       (dx),
    .tx_ready_o (tx_ready),
    .tx_int_o   (tx_int),
    .sr_busy_o  (sr_busy)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_word(logic [W-1:0] d, bit with_rst);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; xmt_rst = with_rst;
    @(negedge clk);
    wr_en = 1'b0; xmt_rst = 1'b0;
  endtask

  // called right after the edge that precedes the load edge
  task automatic measure_ready();
    int n = 0;
    int busy_at_load = 0;
    while (tx_ready !== 1'b1 && n < 20) begin
      @(negedge clk);
      n++;
      if (n == 1) busy_at_load = sr_busy;
    end
    chk("R3 ready latency", n, LAT + 1);
    chk("R5 busy after load", busy_at_load, 1);
    chk("R4 int on ready rise", tx_int, 1);
    @(negedge clk);
    chk("R4 int one cycle", tx_int, 0);
  endtask

  task automatic tick(bit fsv, output logic dxs, output logic fss);
    @(negedge clk);
    bit_tick = 1'b1; fs_in = fsv;
    #1;
    dxs = dx; fss = fs_o;
    @(negedge clk);
    bit_tick = 1'b0; fs_in = 1'b0;
  endtask

  // word already loaded and waiting for its sync
  task automatic send_frame(logic [W-1:0] exp_word);
    logic dxs, fss;
    logic [W-1:0] got = '0;
    if (fs_dir) begin
      chk("R7 oe driven", fs_oe, 1);
      tick(1'b0, dxs, fss);
      chk("R7 no sync before first tick", fss, 0);
      tick(1'b0, dxs, fss);
      chk("R7 sync period", fss, 1);
      chk("R6 dx quiet in sync", dxs, 0);
    end else begin
      chk("R8 oe released", fs_oe, 0);
      for (int k = 0; k < 2; k++) begin
        tick(1'b0, dxs, fss);
        chk("R8 no start without sync", dxs, 0);
      end
      chk("R8 still waiting", sr_busy, 1);
      tick(1'b1, dxs, fss);
      chk("R8 fs_o stays low", fss, 0);
    end
    for (int i = 0; i < W; i++) begin
      tick(1'b0, dxs, fss);
      got = {got[W-2:0], dxs};
      if (fss !== 1'b0) chk("R7 sync only once", fss, 0);
    end
    chk("R6 serial word msb first", got, exp_word);
    chk("R5 busy clears after last bit", sr_busy, 0);
    chk("R6 dx quiet after word", dx, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic dxs, fss;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", tx_ready, 1);
    chk("R1 busy in reset", sr_busy, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 ready", tx_ready, 1);
    chk("R1 int", tx_int, 0);
    chk("R1 busy", sr_busy, 0);
    chk("R1 dx", dx, 0);
    chk("R1 fs_o", fs_o, 0);

    // exhaustive words in both sync modes
    for (int m = 0; m < 2; m++) begin
      for (int w = 0; w < (1 << W); w++) begin
        fs_dir = m[0];
        write_word(w[W-1:0], 1'b0);
        chk("R2 ready drops after write", tx_ready, 0);
        measure_ready();
        send_frame(w[W-1:0]);
      end
    end

    // R10: second word waits behind a busy shifter
    fs_dir = 1'b1;
    write_word(4'hA, 1'b0);
    measure_ready();
    write_word(4'h5, 1'b0);
    chk("R10 ready low while queued", tx_ready, 0);
    repeat (4) @(negedge clk);
    chk("R2 ready held until transfer", tx_ready, 0);
    send_frame(4'hA);
    measure_ready();
    send_frame(4'h5);

    // R9: transmit reset drops shifter and buffer
    write_word(4'hC, 1'b0);
    measure_ready();
    write_word(4'h3, 1'b0);
    tick(1'b0, dxs, fss);
    tick(1'b0, dxs, fss);
    tick(1'b0, dxs, fss);
    chk("R9 precondition busy", sr_busy, 1);
    @(negedge clk);
    xmt_rst = 1'b1;
    @(negedge clk);
    xmt_rst = 1'b0;
    chk("R9 busy cleared", sr_busy, 0);
    chk("R9 ready set", tx_ready, 1);
    chk("R9 no int", tx_int, 0);
    chk("R9 dx quiet", dx, 0);
    repeat (6) @(negedge clk);
    chk("R9 buffered word dropped", sr_busy, 0);
    write_word(4'h9, 1'b1);
    repeat (6) @(negedge clk);
    chk("R9 write during reset ignored", sr_busy, 0);
    chk("R9 ready after ignored write", tx_ready, 1);

    // recovery after transmit reset, sampled sync
    fs_dir = 1'b0;
    write_word(4'h6, 1'b0);
    measure_ready();
    send_frame(4'h6);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule